// File: doc/BRIEF.md
# Dual-Channel Word Serializer with FIFO Read Control

This block pulls 32-bit words from the read side of a standard-timing FIFO and turns them into two serial bit streams. The words in the FIFO are interleaved: the first word after reset belongs to channel A, the next to channel B, and so on. The block steers each word to its own channel. It shifts both channels out together, least significant bit first, over a 32-clock frame. A strobe marks the first bit of every frame.

The read enable is driven only when the FIFO reports data and the block has room for another word, so a read is never lost. The A/B selector moves only on reads the FIFO actually accepts. While one frame shifts out, the next A/B pair is fetched. If that pair is still incomplete when the frame ends, both lines go low and a one-cycle underrun pulse is raised. Shifting resumes with a fresh frame as soon as a full pair is held. The FIFO, the serializer and the reset all share one clock.

Top module: `dual_word_serializer`

## Requirements
- R1: `fifo_rd_en` is never high in a cycle where `fifo_empty` is high.
- R2: The block requests a word whenever its pair buffer is not full and no read is still awaiting its data. Reads are issued at most every other cycle, so a word left in a non-empty FIFO is taken within two cycles.
- R3: The first word read after reset goes to channel A. Words then alternate A, B, A, B. The selector advances only on accepted reads, so a FIFO that runs dry between the A word and the B word does not swap the channels.
- R4: Read data is taken from `fifo_rdata` in the cycle after an accepted read, as standard FIFO timing requires.
- R5: A frame lasts 32 cycles. `ser_a` and `ser_b` carry bit k of their words in cycle k of the frame, with bit 0 first, and `frame_start` is high only in cycle 0.
- R6: A frame starts only when both the A word and the B word are held. When the next pair is ready before a frame ends, the next frame follows with no idle cycle, so frame starts are exactly 32 cycles apart.
- R7: If a frame ends and no complete pair is held, `underrun` is high for exactly one cycle. While no frame is running, `ser_a` and `ser_b` are low. The next frame begins once the pair completes.
- R8: Synchronous active-high `rst` clears all outputs, the held words, the bit counter and any read in flight, and returns the selector to channel A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the FIFO read port |
| rst | input | 1 | Synchronous active-high reset |
| fifo_empty | input | 1 | FIFO has no word to give |
| fifo_rdata | input | 32 | FIFO read data, valid the cycle after an accepted read |
| fifo_rd_en | output | 1 | Read request to the FIFO |
| ser_a | output | 1 | Serial stream of channel A |
| ser_b | output | 1 | Serial stream of channel B |
| frame_start | output | 1 | High on the first bit of each frame |
| underrun | output | 1 | One-cycle pulse when a frame ends with no pair ready |

## Verification
The hardest case to reach is a FIFO that empties after the A word of a pair is taken but before its B word arrives. In that case the selector must wait on B through a frame-end underrun and a long idle stretch. The bench reaches it by pushing a lone A word into its FIFO model once the previous frames have drained. It then waits far longer than a frame and pushes the B word only afterwards. A second case resets the block while it holds such a lone A word, then checks that the next pair starts again at channel A.

// File: rtl/dws_pkg.sv
package dws_pkg;
    localparam int WORD_W = 32;
    localparam int CNT_W  = $clog2(WORD_W);
    localparam int N_CH   = 2;

    typedef enum logic {
        CH_A = 1'b0,
        CH_B = 1'b1
    } chan_e;

    typedef struct packed {
        logic [WORD_W-1:0] b;
        logic [WORD_W-1:0] a;
    } word_pair_t;

    function automatic chan_e other_chan(input chan_e c);
        return (c == CH_A) ? CH_B : CH_A;
    endfunction
endpackage

// File: rtl/dws_fetch.sv
module dws_fetch
    import dws_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fifo_empty,
    input  logic [WORD_W-1:0] fifo_rdata,
    input  logic              take,
    output logic              fifo_rd_en,
    output logic              pair_ok,
    output word_pair_t        pair,
    output chan_e             sel
);
    logic  rd_q;
    chan_e rd_ch;
    logic  have_a;
    logic  have_b;
    logic  want;

    // One read in flight at a time; stop once both slots are filled.
    assign want       = !rd_q && !(have_a && have_b);
    assign fifo_rd_en = want && !fifo_empty;
    assign pair_ok    = have_a && have_b;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q   <= 1'b0;
            rd_ch  <= CH_A;
            sel    <= CH_A;
            have_a <= 1'b0;
            have_b <= 1'b0;
            pair   <= '0;
        end else begin
            rd_q <= fifo_rd_en;
            if (fifo_rd_en) begin
                rd_ch <= sel;
                sel   <= other_chan(sel);
            end
            if (take) begin
                have_a <= 1'b0;
                have_b <= 1'b0;
            end
            // Standard FIFO timing: data is on the bus the cycle after the read.
            if (rd_q) begin
                if (rd_ch == CH_A) begin
                    pair.a <= fifo_rdata;
                    have_a <= 1'b1;
                end else begin
                    pair.b <= fifo_rdata;
                    have_b <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/dws_shift.sv
module dws_shift
    import dws_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       pair_ok,
    input  word_pair_t pair,
    output logic       take,
    output logic       active,
    output logic       ser_a,
    output logic       ser_b,
    output logic       frame_start,
    output logic       underrun
);
    logic [CNT_W-1:0]  cnt;
    logic              last;
    logic [WORD_W-1:0] load_word [N_CH];
    logic [WORD_W-1:0] sh        [N_CH];

    assign last = active && (cnt == CNT_W'(WORD_W - 1));
    assign take = pair_ok && (!active || last);

    assign load_word[0] = pair.a;
    assign load_word[1] = pair.b;

    for (genvar g = 0; g < N_CH; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                sh[g] <= '0;
            end else if (take) begin
                sh[g] <= load_word[g];
            end else if (active) begin
                sh[g] <= sh[g] >> 1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= 1'b0;
            cnt      <= '0;
            underrun <= 1'b0;
        end else begin
            underrun <= last && !pair_ok;
            if (take) begin
                active <= 1'b1;
                cnt    <= '0;
            end else if (last) begin
                active <= 1'b0;
                cnt    <= '0;
            end else if (active) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign ser_a       = active && sh[0][0];
    assign ser_b       = active && sh[1][0];
    assign frame_start = active && (cnt == '0);
endmodule

// File: rtl/dual_word_serializer.sv
module dual_word_serializer
    import dws_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fifo_empty,
    input  logic [WORD_W-1:0] fifo_rdata,
    output logic              fifo_rd_en,
    output logic              ser_a,
    output logic              ser_b,
    output logic              frame_start,
    output logic              underrun
);
    logic       take;
    logic       pair_ok;
    logic       active;
    word_pair_t pair;
    chan_e      sel;

    dws_fetch u_fetch (
        .clk        (clk),
        .rst        (rst),
        .fifo_empty (fifo_empty),
        .fifo_rdata (fifo_rdata),
        .take       (take),
        .fifo_rd_en (fifo_rd_en),
        .pair_ok    (pair_ok),
        .pair       (pair),
        .sel        (sel)
    );

    dws_shift u_shift (
        .clk         (clk),
        .rst         (rst),
        .pair_ok     (pair_ok),
        .pair        (pair),
        .take        (take),
        .active      (active),
        .ser_a       (ser_a),
        .ser_b       (ser_b),
        .frame_start (frame_start),
        .underrun    (underrun)
    );
endmodule

// File: rtl/dws_checker.sv
module dws_checker
    import dws_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  fifo_empty,
    input logic  fifo_rd_en,
    input logic  ser_a,
    input logic  ser_b,
    input logic  frame_start,
    input logic  underrun,
    input logic  active,
    input chan_e sel
);
    AST_RD_ONLY_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
        fifo_rd_en |-> !fifo_empty); // R1
    AST_RD_SPACED: assert property (@(posedge clk) disable iff (rst)
        fifo_rd_en |=> !fifo_rd_en); // R2
    AST_SEL_ADVANCES: assert property (@(posedge clk) disable iff (rst)
        fifo_rd_en |=> (sel != $past(sel))); // R3
    AST_SEL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !fifo_rd_en |=> $stable(sel)); // R3
    AST_FRAME_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> !frame_start); // R5
    AST_UNDERRUN_PULSE: assert property (@(posedge clk) disable iff (rst)
        underrun |=> !underrun); // R7
    AST_UNDERRUN_QUIET: assert property (@(posedge clk) disable iff (rst)
        underrun |-> (!ser_a && !ser_b && !frame_start)); // R7
    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        !active |-> (!ser_a && !ser_b)); // R7
endmodule

bind dual_word_serializer dws_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .fifo_empty  (fifo_empty),
    .fifo_rd_en  (fifo_rd_en),
    .ser_a       (ser_a),
    .ser_b       (ser_b),
    .frame_start (frame_start),
    .underrun    (underrun),
    .active      (active),
    .sel         (sel)
);

// File: tb/dual_word_serializer_test.sv
module dual_word_serializer_test;
    localparam int W     = 32;
    localparam int NVEC  = 6;
    localparam int MAXEX = 16;

    localparam logic [W-1:0] VEC [NVEC][2] = '{
        '{32'h8000_0001, 32'h0000_0000},
        '{32'hA5A5_5A5A, 32'hFFFF_FFFF},
        '{32'h1234_5678, 32'h9ABC_DEF0},
        '{32'h0000_0001, 32'h8000_0000},
        '{32'hDEAD_BEEF, 32'h0F0F_F0F0},
        '{32'h7FFF_FFFE, 32'h0000_FFFF}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         fifo_empty;
    logic [W-1:0] fifo_rdata;
    logic         fifo_rd_en;
    logic         ser_a, ser_b, frame_start, underrun;

    // bench FIFO model, standard read timing
    logic [W-1:0] mem [64];
    logic [5:0]   wp = '0;
    logic [5:0]   rp = '0;
    logic         flush = 1'b0;

    int checks = 0;
    int fails  = 0;

    logic [W-1:0] exp_a [MAXEX];
    logic [W-1:0] exp_b [MAXEX];
    int n_exp  = 0;
    int n_done = 0;
    int n_urun = 0;
    int cyc    = 0;
    int last_fs = -1;
    logic cont  = 1'b0;
    logic coll  = 1'b0;
    int bitn    = 0;
    logic [W-1:0] got_a, got_b;

    always #10 clk = ~clk;

    assign fifo_empty = (wp == rp);

    always @(posedge clk) begin
        if (flush) begin
            rp <= wp;
        end else if (fifo_rd_en && !fifo_empty) begin
            fifo_rdata <= mem[rp];
            rp <= rp + 1'b1;
        end
    end

    dual_word_serializer uut (
        .clk         (clk),
        .rst         (rst),
        .fifo_empty  (fifo_empty),
        .fifo_rdata  (fifo_rdata),
        .fifo_rd_en  (fifo_rd_en),
        .ser_a       (ser_a),
        .ser_b       (ser_b),
        .frame_start (frame_start),
        .underrun    (underrun)
    );

    task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: sample away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (rst) begin
            coll = 1'b0;
            bitn = 0;
        end else begin
            if (fifo_rd_en && fifo_empty) check(1'b0, "R1 read while empty", 1, 0);
            if (underrun) n_urun++;
            if (frame_start) begin
                if (coll) check(1'b0, "R5 frame restarted early", W'(bitn), W'(W));
                if (cont && last_fs >= 0)
                    check(cyc - last_fs == W, "R6 frame spacing", W'(cyc - last_fs), W'(W));
                last_fs = cyc;
                coll = 1'b1;
                bitn = 0;
            end
            if (coll) begin
                got_a[bitn] = ser_a;
                got_b[bitn] = ser_b;
                bitn++;
                if (bitn == W) begin
                    coll = 1'b0;
                    if (n_done < n_exp) begin
                        check(got_a == exp_a[n_done], "R3 R4 R5 channel A word", got_a, exp_a[n_done]);
                        check(got_b == exp_b[n_done], "R3 R4 R5 channel B word", got_b, exp_b[n_done]);
                    end else begin
                        check(1'b0, "R6 unexpected frame", got_a, '0);
                    end
                    n_done++;
                end
            end else if (!frame_start) begin
                if (ser_a || ser_b) check(1'b0, "R7 lines not low when idle", {ser_a, ser_b}, 0);
            end
        end
    end

    task automatic push_word(input logic [W-1:0] w);
        @(negedge clk);
        mem[wp] = w;
        wp = wp + 1'b1;
    endtask

    task automatic expect_pair(input logic [W-1:0] a, input logic [W-1:0] b);
        exp_a[n_exp] = a;
        exp_b[n_exp] = b;
        n_exp++;
    endtask

    task automatic wait_done(input int target);
        int t = 0;
        while (n_done < target && t < 3000) begin
            @(negedge clk);
            t++;
        end
        check(n_done >= target, "R6 frames completed", W'(n_done), W'(target));
    endtask

    task automatic check_reset_outputs(input string tag);
        check(!ser_a && !ser_b && !frame_start && !underrun && !fifo_rd_en,
              tag, {ser_a, ser_b, frame_start, underrun, fifo_rd_en}, '0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : stim
        repeat (4) @(negedge clk);
        check_reset_outputs("R8 reset state");
        @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check_reset_outputs("R8 idle after reset, FIFO empty");

        // table phase: continuous pairs
        cont = 1'b1;
        for (int i = 0; i < NVEC; i++) begin
            expect_pair(VEC[i][0], VEC[i][1]);
            push_word(VEC[i][0]);
            push_word(VEC[i][1]);
        end
        wait_done(NVEC);
        cont = 1'b0;
        repeat (4) @(negedge clk);
        check(n_urun == 1, "R7 underrun after drain", W'(n_urun), 1);

        // lone A word, FIFO dry for well over a frame
        push_word(32'hC0DE_0A0A);
        repeat (3) @(negedge clk);
        check(fifo_empty, "R2 lone word fetched", W'(fifo_empty), 1);
        repeat (100) @(negedge clk);
        check(n_done == NVEC, "R6 no frame with half pair", W'(n_done), W'(NVEC));
        check(n_urun == 1, "R7 no underrun while idle", W'(n_urun), 1);
        expect_pair(32'hC0DE_0A0A, 32'h0B0B_FACE);
        push_word(32'h0B0B_FACE);
        wait_done(NVEC + 1);
        repeat (4) @(negedge clk);
        check(n_urun == 2, "R7 second underrun", W'(n_urun), 2);

        // reset while a lone A word is held
        push_word(32'h1111_2222);
        repeat (6) @(negedge clk);
        rst = 1'b1;
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        @(negedge clk);
        check_reset_outputs("R8 reset mid pair");
        rst = 1'b0;
        expect_pair(32'h3333_4444, 32'h5555_6666);
        push_word(32'h3333_4444);
        push_word(32'h5555_6666);
        wait_done(NVEC + 2);
        check(n_urun == 2, "R8 reset cleared underrun path", W'(n_urun), 2);

        repeat (40) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule